// File: doc/BRIEF.md
# Vector Mask Compare and Masked Subtract Unit

This block holds a small file of integer vector registers together with one mask register that has a bit for each element position. A compare command tests each element of a source vector against a scalar and records the outcome of an inequality test in the mask. A later masked subtract command forms the element-wise difference of two source vectors. It writes that difference into a destination vector only where the mask bit is set. Positions whose mask bit is clear keep their old contents, so a conditional update over a whole vector takes two commands and no branches.

Elements go through a two-stage pipeline at one per clock. The first stage reads the operands and the second stage writes the result. The number of elements in an operation comes with the command and is capped at the register length. A clear command sets every mask bit, so a later subtract acts on every element. A load port and a combinational read port give direct access to any element of any register, so operands can be preloaded and results inspected.

Top module: `vmask_unit`

## Requirements
- R1: After reset every element of every register is zero, every mask bit is 1 and `busy` is low.
- R2: While `busy` is low, `ld_en` writes `ld_data` into element `ld_idx` of register `ld_reg` at the clock edge. A load presented while `busy` is high is ignored. `rd_data` always shows element `rd_idx` of register `rd_reg`.
- R3: The compare command (`cmd_op` = 1) sets mask bit i to 1 when element i of register `cmd_va` differs from `cmd_scalar`, and to 0 when they are equal, for every i below the operation length. Mask bits at or above the length are unchanged.
- R4: The masked subtract command (`cmd_op` = 2) writes element i of `cmd_va` minus element i of `cmd_vb`, modulo 2^W, into element i of `cmd_vd` wherever mask bit i is 1 and i is below the length. Every other element of `cmd_vd` keeps its value. The destination may be one of the sources.
- R5: The clear command (`cmd_op` = 3) sets all mask bits to 1 at the accepting clock edge and does not raise `busy`.
- R6: A compare or subtract is accepted at an edge where `cmd_valid` is high and `busy` is low. Take N as the effective length. `busy` is high for exactly N+1 cycles beginning right after that edge, and the result for element i becomes visible at the (i+2)-th edge after acceptance.
- R7: A command presented while `busy` is high is ignored.
- R8: A length above the register length is treated as the register length. A length of 0 changes nothing but still holds `busy` high for one cycle.
- R9: The mask does not change during a masked subtract. Command code 0 is accepted without effect and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 2 | Register selected for a load |
| ld_idx | input | 6 | Element selected for a load |
| ld_data | input | 64 | Value to load |
| rd_reg | input | 2 | Register selected for the read port |
| rd_idx | input | 6 | Element selected for the read port |
| rd_data | output | 64 | Selected element, combinational |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 compare, 2 masked subtract, 3 clear mask |
| cmd_vd | input | 2 | Destination register of a subtract |
| cmd_va | input | 2 | First source register |
| cmd_vb | input | 2 | Second source register of a subtract |
| cmd_scalar | input | 64 | Scalar operand of a compare |
| cmd_vl | input | 7 | Operation length in elements |
| busy | output | 1 | Operation in progress |
| mask | output | 64 | Mask register, bit i for element i |

## Verification
Every result has a fixed due cycle counted from the edge that accepts the command. `busy` is high after that edge and stays high for N+1 cycles. Mask bit i changes at the (i+2)-th edge, and the subtracted element i lands on that same edge. During each command the bench samples `busy` and the whole mask at every falling edge. It compares them with a reference that advances one element per cycle from the second edge onward. Destination contents go onto a scoreboard queue and are read back only after `busy` falls, when every write of the command is certain to have landed.

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int NREG  = 4,
  parameter int NELEM = 64,
  parameter int W     = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM),
  localparam int LW   = $clog2(NELEM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_reg,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic [RW-1:0] rd_reg,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_vd,
  input  logic [RW-1:0] cmd_va,
  input  logic [RW-1:0] cmd_vb,
  input  logic [W-1:0]  cmd_scalar,
  input  logic [LW-1:0] cmd_vl,
  output logic          busy,
  output logic [NELEM-1:0] mask
);
  localparam logic [1:0] OP_CMP = 2'd1;
  localparam logic [1:0] OP_SUB = 2'd2;
  localparam logic [1:0] OP_CLR = 2'd3;

  logic [W-1:0]  vr [NREG][NELEM];
  logic          run;
  logic [LW-1:0] idx, vl_q;
  logic [1:0]    op_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [W-1:0]  sc_q;
  logic          s1_v;
  logic [IW-1:0] s1_i;
  logic [W-1:0]  s1_a, s1_b;

  wire accept = cmd_valid & ~busy;
  wire start  = accept & ((cmd_op == OP_CMP) | (cmd_op == OP_SUB));
  wire [LW-1:0] vl_clamp = (cmd_vl > LW'(NELEM)) ? LW'(NELEM) : cmd_vl;
  wire [IW-1:0] ridx = idx[IW-1:0];

  assign busy    = run | s1_v;
  assign rd_data = vr[rd_reg][rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      idx  <= '0;
      vl_q <= '0;
      op_q <= '0;
      vd_q <= '0;
      va_q <= '0;
      vb_q <= '0;
      sc_q <= '0;
      s1_v <= 1'b0;
      s1_i <= '0;
      s1_a <= '0;
      s1_b <= '0;
    end else if (start) begin
      run  <= 1'b1;
      idx  <= '0;
      vl_q <= vl_clamp;
      op_q <= cmd_op;
      vd_q <= cmd_vd;
      va_q <= cmd_va;
      vb_q <= cmd_vb;
      sc_q <= cmd_scalar;
    end else if (run) begin
      if (idx < vl_q) begin
        s1_v <= 1'b1;
        s1_i <= ridx;
        s1_a <= vr[va_q][ridx];
        s1_b <= vr[vb_q][ridx];
        idx  <= idx + LW'(1);
        run  <= (idx + LW'(1)) < vl_q;
      end else begin
        run  <= 1'b0;
        s1_v <= 1'b0;
      end
    end else begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask <= '1;
    else if (accept && cmd_op == OP_CLR)
      mask <= '1;
    else if (s1_v && op_q == OP_CMP)
      mask[s1_i] <= (s1_a != sc_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < NELEM; e++)
          vr[r][e] <= '0;
    end else if (s1_v && op_q == OP_SUB) begin
      if (mask[s1_i])
        vr[vd_q][s1_i] <= s1_a - s1_b;
    end else if (ld_en && !busy) begin
      vr[ld_reg][ld_idx] <= ld_data;
    end
  end
endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk #(
  parameter int NELEM = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             busy,
  input logic [NELEM-1:0] mask,
  input logic [1:0]       op_q
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 32'd1;
    else           busy_cnt <= '0;
  end

  p_issue_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> busy);

  p_no_spurious_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2))) |=> !busy);

  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd3) |=> (mask == '1 && !busy));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == 2'd2) |=> $stable(mask));

  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 32'(NELEM + 1));
endmodule

bind vmask_unit vmask_unit_chk #(.NELEM(NELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .mask(mask), .op_q(op_q)
);

// File: tb/vmask_unit_tb.sv
`timescale 1ns/1ps
module vmask_unit_tb;
  localparam int NREG = 4, NELEM = 64, W = 64;
  localparam real HALF = 4.0;

  typedef struct { int r; int i; logic [W-1:0] e; string t; } item_t;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0;
  logic [1:0] ld_reg = 0;
  logic [5:0] ld_idx = 0;
  logic [W-1:0] ld_data = 0;
  logic [1:0] rd_reg = 0;
  logic [5:0] rd_idx = 0;
  logic [W-1:0] rd_data;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0, cmd_vd = 0, cmd_va = 0, cmd_vb = 0;
  logic [W-1:0] cmd_scalar = 0;
  logic [6:0] cmd_vl = 0;
  logic busy;
  logic [NELEM-1:0] mask;

  logic [W-1:0] mdl [NREG][NELEM];
  logic [NELEM-1:0] mmask;
  item_t sb[$];
  bit draining = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  vmask_unit u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // monitor: drains the scoreboard whenever the unit is idle
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!busy && sb.size() > 0) begin
        draining = 1;
        while (sb.size() > 0) begin
          it = sb.pop_front();
          rd_reg = 2'(it.r);
          rd_idx = 6'(it.i);
          #0.05;
          chk(rd_data === it.e, it.t, rd_data, it.e);
        end
        draining = 0;
      end
    end
  end

  task automatic expect_elem(input int r, input int i, input string t);
    item_t it;
    it.r = r; it.i = i; it.e = mdl[r][i]; it.t = t;
    sb.push_back(it);
  endtask

  task automatic flush();
    wait (sb.size() == 0 && !draining);
    @(negedge clk);
  endtask

  task automatic load(input int r, input int i, input logic [W-1:0] d);
    ld_en = 1; ld_reg = 2'(r); ld_idx = 6'(i); ld_data = d;
    @(negedge clk);
    ld_en = 0;
    mdl[r][i] = d;
  endtask

  // issue one compare or subtract and check busy and mask every cycle
  task automatic run_cmd(input logic [1:0] op, input int vd, input int va, input int vb,
                         input logic [W-1:0] sc, input int vl, input bit poke, input string tag);
    int n;
    logic [NELEM-1:0] oldm, newm, expm;
    n = (vl > NELEM) ? NELEM : vl;
    oldm = mmask;
    newm = mmask;
    if (op == 2'd1)
      for (int i = 0; i < n; i++) newm[i] = (mdl[va][i] != sc);
    cmd_valid = 1; cmd_op = op; cmd_vd = 2'(vd); cmd_va = 2'(va); cmd_vb = 2'(vb);
    cmd_scalar = sc; cmd_vl = 7'(vl);
    @(negedge clk);
    cmd_valid = 0;
    for (int k = 0; k <= n + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 1) begin
        cmd_valid = 1; cmd_op = 2'd3;
        ld_en = 1; ld_reg = 2'd1; ld_idx = 6'd0; ld_data = 64'd777;
      end
      if (poke && k == 2) begin
        cmd_valid = 0; ld_en = 0;
      end
      chk(busy === (k <= n), {tag, " R6 busy"}, W'(busy), W'(k <= n));
      expm = oldm;
      for (int i = 0; i < n; i++) if (i <= k - 2) expm[i] = newm[i];
      chk(mask === expm, (op == 2'd2) ? {tag, " R9 mask hold"} : {tag, " R3 mask"}, W'(mask), W'(expm));
    end
    mmask = newm;
    if (op == 2'd2) begin
      for (int i = 0; i < n; i++)
        if (mmask[i]) mdl[vd][i] = mdl[va][i] - mdl[vb][i];
      for (int i = 0; i < NELEM; i++) expect_elem(vd, i, {tag, " R4 element"});
    end
    flush();
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < NELEM; e++) mdl[r][e] = '0;
    mmask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0, "R1 busy", W'(busy), 0);
    chk(mask === '1, "R1 mask", W'(mask), {W{1'b1}});
    for (int r = 0; r < NREG; r++) begin
      expect_elem(r, 0, "R1 zero");
      expect_elem(r, NELEM - 1, "R1 zero");
    end
    flush();

    // R2 operand loads
    for (int i = 0; i < NELEM; i++) begin
      load(0, i, (i % 4 == 0) ? 64'd5 : 64'(i * 7 + 1));
      load(1, i, 64'(i * 3 + 100));
      load(2, i, 64'hFFFF_0000_0000_0000 ^ 64'(i));
    end
    for (int i = 0; i < NELEM; i += 9) begin
      expect_elem(0, i, "R2 load");
      expect_elem(1, i, "R2 load");
      expect_elem(2, i, "R2 load");
    end
    flush();

    run_cmd(2'd1, 0, 0, 0, 64'd5, 64, 0, "cmp full");       // R3
    run_cmd(2'd2, 3, 0, 1, 64'd0, 64, 0, "sub full");       // R4 with wrap
    run_cmd(2'd1, 0, 1, 0, 64'd109, 10, 0, "cmp short");    // R3 length boundary
    run_cmd(2'd2, 0, 0, 2, 64'd0, 20, 0, "sub in place");   // R4 vd == va

    // R5 clear
    cmd_valid = 1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 0;
    mmask = '1;
    chk(mask === '1, "R5 clear mask", W'(mask), {W{1'b1}});
    chk(busy === 1'b0, "R5 clear busy", W'(busy), 0);

    run_cmd(2'd2, 2, 1, 0, 64'd0, 100, 0, "sub clamp");     // R8 length above limit
    run_cmd(2'd1, 0, 0, 0, 64'd5, 64, 0, "cmp again");      // R3
    run_cmd(2'd1, 0, 1, 0, 64'd12345, 0, 0, "cmp zero");    // R8 length 0
    run_cmd(2'd2, 3, 2, 1, 64'd0, 8, 1, "sub poked");       // R7 and R2 ignored while busy
    expect_elem(1, 0, "R2 load while busy ignored");
    flush();

    // R9 command code 0
    cmd_valid = 1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy === 1'b0, "R9 nop busy", W'(busy), 0);
    chk(mask === mmask, "R9 nop mask", W'(mask), W'(mmask));
    @(negedge clk);
    chk(busy === 1'b0, "R9 nop busy later", W'(busy), 0);

    summary();
    $finish;
  end
endmodule